// File: doc/BRIEF.md
# Voice Trigger Mode Controller

This block sits between the trigger pins of a voice-message player and its playback engine. It turns debounced key presses, a stepping key and a CPU address strobe into three results: a group number, a one-cycle start pulse and a one-cycle stop pulse. Two mode pins choose how the inputs are read. In key mode the eight key lines, read as a binary pattern, pick one of the first 32 groups, and the stepping key plays groups one after another. In parallel mode the same eight lines carry a group address that is captured when the strobe rises. The other two mode codes belong to other parts of the chip and produce nothing here.

Each group has three option bits, supplied by an external table through a combinational lookup port. They decide whether the group starts on a press or on a held level, whether it plays only while its trigger is held, and whether a new press during playback restarts playback. All trigger inputs pass a two-flop synchroniser and a debouncer. The debouncer counts ticks of the sample clock, with a long or short window chosen by one input. A synchronous halt input ends playback at once and blocks new starts while it is high. The player reports the natural end of a group on `play_done`.

Top module: `vtrig_ctrl`

## Requirements
- R1: Mode code 00 selects key mode and 01 selects parallel mode. While `mode[1]` is 1 (codes 10 and 11), no start pulse is produced and key or strobe activity has no effect.
- R2: In key mode the debounced key pattern, read as binary with `keys[0]` as LSB, selects the group. Patterns 1 to 32 are valid. Pattern 0 means no key, and patterns above 32 produce no start.
- R3: In key mode with no key pressed, each accepted press of `step_key` starts the group held in a step pointer. The pointer is 1 after reset, advances by one per step start, and returns to 1 after group N_GROUPS (254).
- R4: In parallel mode a debounced rising edge on `step_key` captures `keys` as an address (`keys[0]` LSB, `keys[7]` MSB) and starts that group. Addresses 0 and 255 produce no start.
- R5: `opt_grp` shows the candidate group in the same cycle, and `opt_bits` returns its options: bit 0 = 1 for edge trigger and 0 for level, bit 1 = 1 for holdable, bit 2 = 1 for retriggerable.
- R6: An edge group starts only on a new accepted press. A level group also starts whenever playback is idle and its trigger is still held, so it repeats after `play_done` while held.
- R7: A holdable group ends with a stop pulse carrying its group number when its trigger is released or changed. An unholdable group plays until `play_done` and raises no stop pulse on release.
- R8: During playback of a retriggerable group, a new accepted press of a valid group gives a fresh start pulse with the new group number. A non-retriggerable group ignores such presses.
- R9: A trigger input must stay unchanged for 128 ticks (`long_db`=1) or 1 tick (`long_db`=0) before it is accepted. Shorter changes are ignored.
- R10: When `halt` is high during playback, a stop pulse follows on the next cycle. No start pulse follows any cycle in which `halt` is high. After `halt` falls, a held level trigger starts again.
- R11: After reset `start_o`, `stop_o` and `grp_o` are 0. `grp_o` changes only in the cycle `start_o` is high, and `start_o` and `stop_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle sample-clock tick used by the debouncers |
| mode | input | 2 | Operating mode code |
| keys | input | 8 | Key lines / parallel address |
| step_key | input | 1 | Stepping key in key mode, address strobe in parallel mode |
| halt | input | 1 | Synchronous playback stop, also blocks starts |
| long_db | input | 1 | 1 selects the long debounce window |
| play_done | input | 1 | Player reports the current group has finished |
| opt_grp | output | 8 | Group whose options are requested |
| opt_bits | input | 3 | Options of `opt_grp` {retrig, hold, edge} |
| grp_o | output | 8 | Group number of the latest start |
| start_o | output | 1 | Start request pulse |
| stop_o | output | 1 | Stop request pulse |

## Verification
A wrong busy flag, step pointer or stored option set shows up at the start and stop pulses on the very next trigger. Examples are a missing restart, an unexpected stop on release, or a group number one off in the stepping sequence. The scoreboard compares the order and group number of every pulse against a queue filled by the stimulus tasks, so a single extra or missing pulse is reported at that pulse. Debounce errors move the pulse in time, so the long window is checked at a point where no pulse may have appeared yet.

// File: rtl/vtrig_pkg.sv
package vtrig_pkg;

  typedef enum logic [1:0] {
    MODE_KEY  = 2'b00,
    MODE_PAR  = 2'b01,
    MODE_SER  = 2'b10,
    MODE_PROG = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    SRC_KEY = 2'd0,
    SRC_STEP = 2'd1,
    SRC_PAR = 2'd2
  } src_e;

  // bit 0 edge, bit 1 hold, bit 2 retrigger
  typedef struct packed {
    logic retrig;
    logic hold;
    logic edge_trig;
  } gopt_t;

  function automatic logic grp_in_range(input int unsigned g, input int unsigned top);
    return (g != 0) && (g <= top);
  endfunction

  function automatic int unsigned step_next(input int unsigned p, input int unsigned top);
    return (p >= top) ? 1 : p + 1;
  endfunction

  function automatic int unsigned deb_window(input logic long_sel, input int unsigned lng,
                                             input int unsigned sht);
    return long_sel ? lng : sht;
  endfunction

endpackage

// File: rtl/vtrig_deb.sv
module vtrig_deb #(
  parameter int unsigned W           = 8,
  parameter int unsigned LONG_TICKS  = 128,
  parameter int unsigned SHORT_TICKS = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         long_sel,
  input  logic [W-1:0] raw,
  output logic [W-1:0] stable,
  output logic         changed
);
  import vtrig_pkg::*;

  localparam int unsigned MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int unsigned CW   = $clog2(MAXT + 1);

  logic [W-1:0]  s1, s2, s3;
  logic [CW-1:0] cnt;
  logic          win_full;

  assign win_full = (32'(cnt) + 1) >= deb_window(long_sel, LONG_TICKS, SHORT_TICKS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1      <= '0;
      s2      <= '0;
      s3      <= '0;
      stable  <= '0;
      cnt     <= '0;
      changed <= 1'b0;
    end else begin
      s1      <= raw;
      s2      <= s1;
      s3      <= s2;
      changed <= 1'b0;
      if (s2 == stable || s2 != s3) begin
        cnt <= '0;
      end else if (tick) begin
        if (win_full) begin
          stable  <= s2;
          changed <= 1'b1;
          cnt     <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/vtrig_src.sv
module vtrig_src #(
  parameter int unsigned GW         = 8,
  parameter int unsigned N_GROUPS   = 254,
  parameter int unsigned KEY_GROUPS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [GW-1:0]     deb_keys,
  input  logic              keys_chg,
  input  logic              deb_step,
  input  logic              step_chg,
  input  logic              fire,
  output vtrig_pkg::src_e   cand_src,
  output logic [GW-1:0]     cand_grp,
  output logic              cand_event,
  output logic              cand_held,
  output logic              cand_valid,
  output logic              mode_on
);
  import vtrig_pkg::*;

  logic [GW-1:0] step_ptr;
  logic [GW-1:0] par_addr;
  logic          step_rise;
  logic          key_press;

  assign step_rise = step_chg & deb_step;
  assign key_press = keys_chg & (deb_keys != '0);

  always_comb begin
    cand_src   = SRC_KEY;
    cand_grp   = deb_keys;
    cand_event = 1'b0;
    cand_held  = 1'b0;
    cand_valid = 1'b0;
    mode_on    = 1'b0;
    case (mode_e'(mode))
      MODE_PAR: begin
        mode_on    = 1'b1;
        cand_src   = SRC_PAR;
        cand_grp   = step_rise ? deb_keys : par_addr;
        cand_event = step_rise;
        cand_held  = deb_step;
        cand_valid = grp_in_range(32'(cand_grp), N_GROUPS);
      end
      MODE_KEY: begin
        mode_on = 1'b1;
        if (step_rise || (deb_step && deb_keys == '0 && !key_press)) begin
          cand_src   = SRC_STEP;
          cand_grp   = step_ptr;
          cand_event = step_rise;
          cand_held  = deb_step;
          cand_valid = grp_in_range(32'(step_ptr), N_GROUPS);
        end else begin
          cand_src   = SRC_KEY;
          cand_grp   = deb_keys;
          cand_event = key_press;
          cand_held  = deb_keys != '0;
          cand_valid = grp_in_range(32'(deb_keys), KEY_GROUPS);
        end
      end
      default: mode_on = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_ptr <= GW'(1);
      par_addr <= '0;
    end else begin
      if (mode_e'(mode) == MODE_PAR && step_rise)
        par_addr <= deb_keys;
      if (fire && cand_src == SRC_STEP)
        step_ptr <= GW'(step_next(32'(step_ptr), N_GROUPS));
    end
  end

endmodule

// File: rtl/vtrig_play.sv
module vtrig_play #(
  parameter int unsigned GW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt,
  input  logic              play_done,
  input  logic              mode_on,
  input  vtrig_pkg::src_e   cand_src,
  input  logic [GW-1:0]     cand_grp,
  input  logic              cand_event,
  input  logic              cand_held,
  input  logic              cand_valid,
  input  vtrig_pkg::gopt_t  cand_opt,
  input  logic [GW-1:0]     deb_keys,
  input  logic              deb_step,
  output logic              fire,
  output logic              hold_lost,
  output logic              halt_stop,
  output logic              busy,
  output logic              cur_retrig,
  output logic              cur_src_key,
  output logic [GW-1:0]     grp_o,
  output logic              start_o,
  output logic              stop_o
);
  import vtrig_pkg::*;

  src_e          cur_src;
  gopt_t         cur_opt;
  logic          cur_held;
  logic          want_new;
  logic          want_lvl;

  assign want_new  = cand_event && (!busy || cur_opt.retrig);
  assign want_lvl  = !busy && cand_held && !cand_opt.edge_trig;
  assign fire      = mode_on && cand_valid && !halt && (want_new || want_lvl);
  assign cur_held  = (cur_src == SRC_KEY) ? (deb_keys == grp_o) : deb_step;
  assign hold_lost = busy && cur_opt.hold && !cur_held && !fire;
  assign halt_stop = busy && halt;

  assign cur_retrig  = cur_opt.retrig;
  assign cur_src_key = (cur_src == SRC_KEY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cur_src <= SRC_KEY;
      cur_opt <= '0;
      grp_o   <= '0;
      start_o <= 1'b0;
      stop_o  <= 1'b0;
    end else begin
      start_o <= fire;
      stop_o  <= halt_stop | hold_lost;
      if (fire) begin
        busy    <= 1'b1;
        cur_src <= cand_src;
        cur_opt <= cand_opt;
        grp_o   <= cand_grp;
      end else if (halt_stop || hold_lost || play_done) begin
        busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vtrig_ctrl.sv
module vtrig_ctrl #(
  parameter int unsigned KEYS        = 8,
  parameter int unsigned N_GROUPS    = 254,
  parameter int unsigned KEY_GROUPS  = 32,
  parameter int unsigned LONG_TICKS  = 128,
  parameter int unsigned SHORT_TICKS = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [1:0]      mode,
  input  logic [KEYS-1:0] keys,
  input  logic            step_key,
  input  logic            halt,
  input  logic            long_db,
  input  logic            play_done,
  output logic [KEYS-1:0] opt_grp,
  input  logic [2:0]      opt_bits,
  output logic [KEYS-1:0] grp_o,
  output logic            start_o,
  output logic            stop_o
);
  import vtrig_pkg::*;

  localparam int unsigned GW = KEYS;

  logic [GW-1:0] deb_keys;
  logic          keys_chg;
  logic          deb_step;
  logic          step_chg;
  src_e          cand_src;
  logic [GW-1:0] cand_grp;
  logic          cand_event, cand_held, cand_valid, mode_on;
  gopt_t         cand_opt;
  logic          fire, hold_lost, halt_stop, busy, cur_retrig, cur_src_key;

  vtrig_deb #(.W(GW), .LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_deb_keys (
    .clk(clk), .rst_n(rst_n), .tick(tick), .long_sel(long_db),
    .raw(keys), .stable(deb_keys), .changed(keys_chg)
  );

  vtrig_deb #(.W(1), .LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_deb_step (
    .clk(clk), .rst_n(rst_n), .tick(tick), .long_sel(long_db),
    .raw(step_key), .stable(deb_step), .changed(step_chg)
  );

  vtrig_src #(.GW(GW), .N_GROUPS(N_GROUPS), .KEY_GROUPS(KEY_GROUPS)) u_src (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .deb_keys(deb_keys), .keys_chg(keys_chg), .deb_step(deb_step), .step_chg(step_chg),
    .fire(fire), .cand_src(cand_src), .cand_grp(cand_grp), .cand_event(cand_event),
    .cand_held(cand_held), .cand_valid(cand_valid), .mode_on(mode_on)
  );

  assign opt_grp  = cand_grp;
  assign cand_opt = gopt_t'(opt_bits);

  vtrig_play #(.GW(GW)) u_play (
    .clk(clk), .rst_n(rst_n), .halt(halt), .play_done(play_done), .mode_on(mode_on),
    .cand_src(cand_src), .cand_grp(cand_grp), .cand_event(cand_event),
    .cand_held(cand_held), .cand_valid(cand_valid), .cand_opt(cand_opt),
    .deb_keys(deb_keys), .deb_step(deb_step),
    .fire(fire), .hold_lost(hold_lost), .halt_stop(halt_stop), .busy(busy),
    .cur_retrig(cur_retrig), .cur_src_key(cur_src_key),
    .grp_o(grp_o), .start_o(start_o), .stop_o(stop_o)
  );

endmodule

// File: rtl/vtrig_ctrl_chk.sv
module vtrig_ctrl_chk #(
  parameter int unsigned GW         = 8,
  parameter int unsigned N_GROUPS   = 254,
  parameter int unsigned KEY_GROUPS = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          halt,
  input logic          busy,
  input logic          cur_retrig,
  input logic          cur_src_key,
  input logic [GW-1:0] grp_o,
  input logic          start_o,
  input logic          stop_o
);

  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |=> !start_o); // R1

  AST_KEY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && cur_src_key) |-> (32'(grp_o) <= KEY_GROUPS)); // R2

  AST_GRP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (grp_o != '0 && 32'(grp_o) <= N_GROUPS)); // R4

  AST_NO_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cur_retrig) |=> !start_o); // R8

  AST_HALT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && halt) |=> (stop_o && !busy)); // R10

  AST_HALT_NOSTART: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !start_o); // R10

  AST_GRP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start_o |-> $stable(grp_o)); // R11

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_o && stop_o)); // R11

endmodule

bind vtrig_ctrl vtrig_ctrl_chk #(.GW(GW), .N_GROUPS(N_GROUPS), .KEY_GROUPS(KEY_GROUPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .halt(halt), .busy(busy),
  .cur_retrig(cur_retrig), .cur_src_key(cur_src_key),
  .grp_o(grp_o), .start_o(start_o), .stop_o(stop_o)
);

// File: tb/vtrig_ctrl_test.sv
module vtrig_ctrl_test;
  localparam int PLAY_LEN = 300;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, long_db = 1'b0;
  logic       step_key = 1'b0, halt = 1'b0, play_done = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] keys = 8'd0;
  logic [7:0] opt_grp, grp_o;
  logic [2:0] opt_bits;
  logic       start_o, stop_o;

  int    n_vec = 0, n_bad = 0, ev_seen = 0, pl_cnt = 0, tk = 0;
  bit    fin = 0;
  string cur_tag = "R11";
  int    q_kind[$];
  int    q_grp[$];
  string q_tag[$];

  always #5 clk = ~clk;

  // R5: option table of the bench, bit0 edge, bit1 hold, bit2 retrigger = group bits 0..2
  assign opt_bits = opt_grp[2:0];

  vtrig_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .keys(keys),
    .step_key(step_key), .halt(halt), .long_db(long_db), .play_done(play_done),
    .opt_grp(opt_grp), .opt_bits(opt_bits), .grp_o(grp_o),
    .start_o(start_o), .stop_o(stop_o)
  );

  // sample tick every 4 clocks, player model
  always @(negedge clk) begin
    tk   <= (tk == 3) ? 0 : tk + 1;
    tick <= (tk == 3);
    play_done <= 1'b0;
    if (start_o) pl_cnt <= PLAY_LEN;
    else if (stop_o) pl_cnt <= 0;
    else if (pl_cnt == 1) begin pl_cnt <= 0; play_done <= 1'b1; end
    else if (pl_cnt > 1) pl_cnt <= pl_cnt - 1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (start_o || stop_o)) begin
      int k, g;
      string t;
      ev_seen++;
      n_vec++;
      if (q_kind.size() == 0) begin
        n_bad++;
        $display("FAIL %s: unexpected %s grp=%0d, expected no pulse", cur_tag,
                 start_o ? "start" : "stop", grp_o);
      end else begin
        k = q_kind.pop_front();
        g = q_grp.pop_front();
        t = q_tag.pop_front();
        if (k != (stop_o ? 1 : 0) || g != int'(grp_o)) begin
          n_bad++;
          $display("FAIL %s: got %s grp=%0d, expected %s grp=%0d", t,
                   stop_o ? "stop" : "start", grp_o, (k == 1) ? "stop" : "start", g);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_ev(input int k, input int g, input string t);
    q_kind.push_back(k);
    q_grp.push_back(g);
    q_tag.push_back(t);
  endtask

  task automatic check(input bit ok, input string t, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic drain(input string t, input int maxc);
    for (int i = 0; i < maxc && q_kind.size() != 0; i++) @(negedge clk);
    check(q_kind.size() == 0, t, q_kind.size(), 0);
    while (q_kind.size() != 0) begin
      void'(q_kind.pop_front()); void'(q_grp.pop_front()); void'(q_tag.pop_front());
    end
  endtask

  task automatic pulse_halt();
    halt = 1'b1; cyc(1); halt = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!fin) begin
      n_bad++;
      $display("FAIL R11: watchdog, actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int e0;
    cyc(4);
    check(start_o == 1'b0, "R11 reset start", start_o, 0);
    check(stop_o == 1'b0, "R11 reset stop", stop_o, 0);
    check(grp_o == 8'd0, "R11 reset grp", grp_o, 0);
    rst_n = 1'b1;
    cyc(10);

    // R6: edge group 1 held past its end does not repeat
    cur_tag = "R6";
    expect_ev(0, 1, "R6 edge start");
    keys = 8'd1; cyc(500); keys = 8'd0; cyc(40);
    drain("R6 edge", 50);

    // R7: unholdable group 5 released early, no stop
    cur_tag = "R7";
    expect_ev(0, 5, "R7 unhold start");
    keys = 8'd5; cyc(40); keys = 8'd0; cyc(400);
    drain("R7 unhold", 10);

    // R7: holdable group 3 stops on release
    expect_ev(0, 3, "R7 hold start");
    expect_ev(1, 3, "R7 hold stop");
    keys = 8'd3; cyc(60); keys = 8'd0; cyc(40);
    drain("R7 hold", 50);

    // R6: level group 8 held across its end restarts once
    cur_tag = "R6";
    expect_ev(0, 8, "R6 level start");
    expect_ev(0, 8, "R6 level restart");
    keys = 8'd8; cyc(400); keys = 8'd0; cyc(400);
    drain("R6 level", 50);

    // R8: non-retriggerable group 1 ignores press of group 2
    cur_tag = "R8";
    expect_ev(0, 1, "R8 nonretrig start");
    keys = 8'd1; cyc(60); keys = 8'd2; cyc(60); keys = 8'd0; cyc(400);
    drain("R8 nonretrig", 10);

    // R8: retriggerable group 5 restarts with group 6 (holdable)
    expect_ev(0, 5, "R8 retrig first");
    expect_ev(0, 6, "R8 retrig new");
    expect_ev(1, 6, "R8 retrig hold stop");
    keys = 8'd5; cyc(60); keys = 8'd6; cyc(60); keys = 8'd0; cyc(40);
    drain("R8 retrig", 50);

    // R2: pattern 33 out of range, 32 valid
    cur_tag = "R2";
    e0 = ev_seen;
    keys = 8'd33; cyc(60); keys = 8'd0; cyc(40);
    check(ev_seen == e0, "R2 pattern 33 ignored", ev_seen - e0, 0);
    expect_ev(0, 32, "R2 pattern 32");
    keys = 8'd32; cyc(60); keys = 8'd0; cyc(400);
    drain("R2 range", 10);

    // R3: step key through all groups and wrap
    cur_tag = "R3";
    for (int k = 1; k <= 255; k++) begin
      int g;
      g = (k == 255) ? 1 : k;
      expect_ev(0, g, "R3 step start");
      expect_ev(1, g, "R3 step stop");
      step_key = 1'b1; cyc(30); step_key = 1'b0; cyc(30);
      pulse_halt(); cyc(5);
    end
    drain("R3 step", 50);

    // R4: parallel address capture
    cur_tag = "R4";
    mode = 2'b01;
    expect_ev(0, 45, "R4 addr 45 start");
    expect_ev(1, 45, "R4 addr 45 halt");
    keys = 8'd45; cyc(30); step_key = 1'b1; cyc(30); step_key = 1'b0; cyc(30);
    pulse_halt(); cyc(10);
    drain("R4 addr 45", 20);
    e0 = ev_seen;
    keys = 8'd0; cyc(30); step_key = 1'b1; cyc(30); step_key = 1'b0; cyc(30);
    keys = 8'd255; cyc(30); step_key = 1'b1; cyc(30); step_key = 1'b0; cyc(30);
    check(ev_seen == e0, "R4 addr 0/255 ignored", ev_seen - e0, 0);
    expect_ev(0, 200, "R4 addr 200 start");
    expect_ev(1, 200, "R4 addr 200 halt");
    keys = 8'd200; cyc(30); step_key = 1'b1; cyc(30); step_key = 1'b0; cyc(30);
    pulse_halt(); cyc(10);
    drain("R4 addr 200", 20);

    // R1: modes 10 and 11 produce nothing
    cur_tag = "R1";
    keys = 8'd0; cyc(30);
    e0 = ev_seen;
    mode = 2'b10; keys = 8'd1; cyc(40); keys = 8'd0; step_key = 1'b1; cyc(40); step_key = 1'b0; cyc(40);
    mode = 2'b11; keys = 8'd3; cyc(40); keys = 8'd0; step_key = 1'b1; cyc(40); step_key = 1'b0; cyc(40);
    check(ev_seen == e0, "R1 modes 10/11 silent", ev_seen - e0, 0);
    mode = 2'b00; cyc(40);

    // R10: halt stops, blocks start, level restarts after release
    cur_tag = "R10";
    expect_ev(0, 4, "R10 start");
    expect_ev(1, 4, "R10 halt stop");
    keys = 8'd4; cyc(40); halt = 1'b1; cyc(100);
    drain("R10 halt stop", 5);
    expect_ev(0, 4, "R10 restart after halt");
    expect_ev(1, 4, "R10 final stop");
    halt = 1'b0; cyc(40); keys = 8'd0; cyc(40); pulse_halt(); cyc(10);
    drain("R10 restart", 20);

    // R9: long debounce
    cur_tag = "R9";
    long_db = 1'b1; cyc(10);
    e0 = ev_seen;
    keys = 8'd1; cyc(200); keys = 8'd0; cyc(100);
    check(ev_seen == e0, "R9 glitch ignored", ev_seen - e0, 0);
    expect_ev(0, 1, "R9 long accept");
    expect_ev(1, 1, "R9 long halt");
    keys = 8'd1; cyc(400);
    check(ev_seen == e0, "R9 not accepted before window", ev_seen - e0, 0);
    cyc(200); pulse_halt(); cyc(10);
    drain("R9 long", 20);
    keys = 8'd0; cyc(700); long_db = 1'b0;

    fin = 1;
    summary();
    $finish;
  end

endmodule